// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a management-interface master that lets software reach the registers of attached Ethernet PHYs over a two-wire serial bus. It produces the bus clock (MDC) and drives or releases the data line (MDIO). Software sees a small bank of registers behind a simple memory-mapped port. One register holds the frame type and the clock divider. Others hold the PHY and register address, the data to send and the data returned. A command register starts a transaction and reports busy.

For one access, software picks the frame type (the short "Clause 22" frame or the "Clause 45" frame with a separate address cycle), loads address and data, and writes a start command with an access code. The block then sends one complete frame: a 32-bit all-ones preamble, start and opcode fields, the two 5-bit address fields, a turnaround and 16 data bits. It changes the data line just as MDC falls. On reads it releases the line from the turnaround onward, samples the PHY's bits on rising MDC edges, and stores them in the read-data register before busy drops.

Top module: `mdio_master`

## Requirements
- R1: After reset the mode register (offset 0x40) reads 0x000000FF (divider field 0xFF in bits 7:0, frame-type bit 8 clear), the command register (0x50) reads busy bit 16 as 0, and MDC and the MDIO output enable are low.
- R2: While a frame runs, MDC has a period of N+1 input clocks, where N is the divider field; this is required for N+1 from 8 up to 256.
- R3: A frame seen on MDIO at rising MDC edges is 32 ones, then start, opcode, 5-bit PHY address (address register bits 12:8), 5-bit register/device field (address register bits 4:0), turnaround and 16 data bits, most significant first. With bit 8 of the mode register clear, access code 1 (command bits 1:0) sends start 01, opcode 01, turnaround 10 and the write-data register (offset 0x48, bits 15:0).
- R4: With bit 8 of the mode register clear, access code 0 sends start 01 and opcode 10, holds the output enable low from the first turnaround bit through the last data bit, and stores the 16 bits sampled at rising MDC edges into bits 15:0 of the read-data register (offset 0x4C), first bit as the most significant.
- R5: With bit 8 of the mode register set, access code 0 sends an address frame: start 00, opcode 00, turnaround 10, and the write-data register as the 16-bit register address.
- R6: With bit 8 of the mode register set, access code 1 sends start 00, opcode 01 with driven turnaround 10 and the write-data register; access code 2 sends start 00, opcode 11 and reads as in R4.
- R7: Busy (command bit 16) reads 1 from the start write until one extra MDC period (with MDIO released) after the last data bit, giving 65 rising MDC edges per frame; the read-data register already holds the new value when busy first reads 0.
- R8: A write of the start bit (command bit 8) while busy is set is ignored: the running frame is unchanged and no second frame follows.
- R9: A start with an undefined access code (2 or 3 with mode bit 8 clear, 3 with it set) is ignored: busy stays 0 and MDC stays low.
- R10: Whenever busy is 0, MDC is low and the MDIO output enable is low.
- R11: The mode, address and write-data registers read back the values written, in the fields named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; MDC is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears one clock later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO line as seen on the pin |

## Verification
The hardest case to reach from the ports is a start command that lands in the middle of a frame already under way, since software normally waits for busy to clear. The bench starts a write frame, waits about a hundred clocks, writes a read start, and then confirms the captured frame is still the original write and that no further MDC edges appear long after busy drops. The read path needs a responder that releases and drives the line in step with MDC, so the bench counts rising edges and puts its data bits on the line at the falling edges that follow the turnaround.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [7:0] OFS_MODE = 8'h40;
  localparam logic [7:0] OFS_ADDR = 8'h44;
  localparam logic [7:0] OFS_WDAT = 8'h48;
  localparam logic [7:0] OFS_RDAT = 8'h4C;
  localparam logic [7:0] OFS_CMD  = 8'h50;

  localparam int MODE_C45_BIT = 8;
  localparam int CMD_GO_BIT   = 8;
  localparam int CMD_BUSY_BIT = 16;

  // start + opcode bits for a given frame type and access code
  function automatic logic [3:0] frame_hdr(input logic c45, input logic [1:0] code);
    if (!c45) frame_hdr = (code == 2'd0) ? 4'b0110 : 4'b0101;
    else begin
      case (code)
        2'd0:    frame_hdr = 4'b0000;
        2'd1:    frame_hdr = 4'b0001;
        default: frame_hdr = 4'b0011;
      endcase
    end
  endfunction

  function automatic logic code_ok(input logic c45, input logic [1:0] code);
    code_ok = c45 ? (code != 2'd3) : (code[1] == 1'b0);
  endfunction

  function automatic logic code_rd(input logic c45, input logic [1:0] code);
    code_rd = c45 ? (code == 2'd2) : (code == 2'd0);
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_n,
  output logic             mdc,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   div_d;
  logic [DIV_W:0]   lo_len;

  always_comb begin
    div_d  = {1'b0, div_n} + 1'b1;
    lo_len = (div_d + 1'b1) >> 1;
    rise_o = run && ({1'b0, cnt} == lo_len - 1'b1);
    fall_o = run && (cnt == div_n);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_o ? '0 : cnt + 1'b1;
      if (fall_o)      mdc <= 1'b0;
      else if (rise_o) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        c45_i,
  input  logic [1:0]  code_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] data_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_we_o,
  output logic [15:0] rd_data_o
);
  import mdio_pkg::*;

  localparam int BODY     = 32;
  localparam int FRAME    = PRE_LEN + BODY;
  localparam int IW       = $clog2(FRAME + 1);
  localparam int TA_FIRST = PRE_LEN + 14;
  localparam int RD_FIRST = PRE_LEN + 16;

  logic [IW-1:0]    idx, nidx;
  logic [FRAME-1:0] shreg, frame_w;
  logic             is_rd, new_rd;
  logic [1:0]       ta_w;

  always_comb begin
    new_rd  = code_rd(c45_i, code_i);
    ta_w    = new_rd ? 2'b11 : 2'b10;
    frame_w = {{PRE_LEN{1'b1}}, frame_hdr(c45_i, code_i), phy_i, reg_i, ta_w, data_i};
    nidx    = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      idx       <= '0;
      shreg     <= '0;
      is_rd     <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
      rd_we_o   <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_we_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          idx     <= '0;
          shreg   <= frame_w;
          is_rd   <= new_rd;
          mdio_o  <= frame_w[FRAME-1];
          mdio_oe <= 1'b1;
        end
      end else begin
        if (rise_i && is_rd && idx >= IW'(RD_FIRST) && idx < IW'(FRAME))
          rd_data_o <= {rd_data_o[14:0], mdio_i};
        if (fall_i) begin
          if (idx == IW'(FRAME)) begin
            busy_o  <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            idx   <= nidx;
            shreg <= shreg << 1;
            if (nidx == IW'(FRAME)) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
            end else begin
              mdio_o  <= shreg[FRAME-2];
              mdio_oe <= !(is_rd && nidx >= IW'(TA_FIRST));
            end
            if (idx == IW'(FRAME-1) && is_rd) rd_we_o <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  out_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(fall_i));
  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && is_rd && idx >= IW'(TA_FIRST)) |-> !mdio_oe);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(idx) == IW'(FRAME) && $past(fall_i)));
  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32,
  parameter int BUS_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  import mdio_pkg::*;

  logic [DIV_W-1:0] div_n;
  logic             c45_mode;
  logic [4:0]       phy_ad;
  logic [7:0]       reg_ad;
  logic [15:0]      wr_dat, rd_dat;
  logic             busy, go, start, rise, fall, rd_we;
  logic [15:0]      eng_rd;
  logic [31:0]      rd_mux;

  always_comb begin
    go    = bus_we && (bus_addr == BUS_AW'(OFS_CMD)) && bus_wdata[CMD_GO_BIT];
    start = go && !busy && code_ok(c45_mode, bus_wdata[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_n    <= '1;
      c45_mode <= 1'b0;
      phy_ad   <= '0;
      reg_ad   <= '0;
      wr_dat   <= '0;
      rd_dat   <= '0;
    end else begin
      if (bus_we) begin
        if (bus_addr == BUS_AW'(OFS_MODE)) begin
          div_n    <= bus_wdata[DIV_W-1:0];
          c45_mode <= bus_wdata[MODE_C45_BIT];
        end
        if (bus_addr == BUS_AW'(OFS_ADDR)) begin
          phy_ad <= bus_wdata[12:8];
          reg_ad <= bus_wdata[7:0];
        end
        if (bus_addr == BUS_AW'(OFS_WDAT)) wr_dat <= bus_wdata[15:0];
      end
      if (rd_we) rd_dat <= eng_rd;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == BUS_AW'(OFS_MODE)) begin
      rd_mux[DIV_W-1:0]    = div_n;
      rd_mux[MODE_C45_BIT] = c45_mode;
    end else if (bus_addr == BUS_AW'(OFS_ADDR)) begin
      rd_mux[12:0] = {phy_ad, reg_ad};
    end else if (bus_addr == BUS_AW'(OFS_WDAT)) begin
      rd_mux[15:0] = wr_dat;
    end else if (bus_addr == BUS_AW'(OFS_RDAT)) begin
      rd_mux[15:0] = rd_dat;
    end else if (bus_addr == BUS_AW'(OFS_CMD)) begin
      rd_mux[CMD_BUSY_BIT] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst(rst), .run(busy), .div_n(div_n),
    .mdc(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start_i(start), .c45_i(c45_mode),
    .code_i(bus_wdata[1:0]), .phy_i(phy_ad), .reg_i(reg_ad[4:0]),
    .data_i(wr_dat), .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .busy_o(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_we_o(rd_we), .rd_data_o(eng_rd)
  );

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
  // R4
  rdreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_dat != $past(rd_dat)) |-> $past(rd_we));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WDAT = 8'h48,
                         A_RDAT = 8'h4C, A_CMD = 8'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_drv = 1'b0, phy_bit = 1'b1;

  int total = 0, bad = 0, rises = 0, cur_div = 255;
  logic [63:0] line_v, oe_v;
  logic [15:0] rsp = '0;
  logic        rsp_en = 1'b0, finished = 1'b0;
  time last_t = 0, per_t = 0;

  always #10 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  mdio_master u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (rises < 64) begin
      line_v[63-rises] = mdio_i;
      oe_v[63-rises]   = mdio_oe;
    end
    per_t  = $time - last_t;
    last_t = $time;
    rises  = rises + 1;
  end

  always @(negedge mdc) begin
    if (rsp_en && rises >= 48 && rises < 64) begin
      phy_drv = 1'b1;
      phy_bit = rsp[63-rises];
    end else phy_drv = 1'b0;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    #2 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic wait_idle(output int seen);
    logic [31:0] d;
    seen = -1;
    for (int i = 0; i < 40000; i++) begin
      bus_read(A_CMD, d);
      if (d[16]) seen = rises;
      else break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] code,
      input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] dat, input logic [15:0] rd);
    logic [3:0] h;
    logic rdf;
    rdf = c45 ? (code == 2'd2) : (code == 2'd0);
    if (!c45) h = rdf ? 4'b0110 : 4'b0101;
    else if (code == 2'd0) h = 4'b0000;
    else if (code == 2'd1) h = 4'b0001;
    else h = 4'b0011;
    exp_frame = {32'hFFFF_FFFF, h, phy, ra, rdf ? 2'b11 : 2'b10, rdf ? rd : dat};
  endfunction

  task automatic set_mode(input logic c45, input int dv);
    cur_div = dv;
    bus_write(A_MODE, {23'd0, c45, 8'(dv)});
  endtask

  task automatic do_frame(input string req, input logic c45, input logic [1:0] code,
      input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] dat, input logic [15:0] rd);
    logic [31:0] d;
    logic rdf;
    int seen;
    rdf = c45 ? (code == 2'd2) : (code == 2'd0);
    bus_write(A_ADDR, {19'd0, phy, 3'd0, ra});
    bus_write(A_WDAT, {16'd0, dat});
    rsp = rd; rsp_en = rdf; rises = 0;
    bus_write(A_CMD, {23'd0, 1'b1, 6'd0, code});
    bus_read(A_CMD, d);
    chk(d[16] == 1'b1, "R7 busy after start", {63'd0, d[16]}, 64'd1);
    wait_idle(seen);
    chk(rises == 65, "R7 edge count", 64'(rises), 64'd65);
    chk(seen == 65, "R7 busy through tail period", 64'(seen), 64'd65);
    chk(line_v == exp_frame(c45, code, phy, ra, dat, rd), req, line_v,
        exp_frame(c45, code, phy, ra, dat, rd));
    chk(oe_v == (rdf ? {{46{1'b1}}, 18'd0} : {64{1'b1}}), "R4 output enable pattern", oe_v,
        rdf ? {{46{1'b1}}, 18'd0} : {64{1'b1}});
    chk(per_t == time'((cur_div + 1) * 20), "R2 MDC period", 64'(per_t), 64'((cur_div + 1) * 20));
    if (rdf) begin
      bus_read(A_RDAT, d);
      chk(d == {16'd0, rd}, "R4 read data register", 64'(d), 64'(rd));
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    rsp_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 R10 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    bus_read(A_MODE, d);
    chk(d == 32'h0000_00FF, "R1 mode reset", 64'(d), 64'hFF);
    bus_read(A_CMD, d);
    chk(d[16] == 1'b0, "R1 busy reset", 64'(d), 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(A_ADDR, 32'h0000_1A37);
    bus_read(A_ADDR, d);
    chk(d == 32'h0000_1A37, "R11 address readback", 64'(d), 64'h1A37);
    bus_write(A_WDAT, 32'h0000_C3A5);
    bus_read(A_WDAT, d);
    chk(d == 32'h0000_C3A5, "R11 wdata readback", 64'(d), 64'hC3A5);
    set_mode(1'b1, 7);
    bus_read(A_MODE, d);
    chk(d == 32'h0000_0107, "R11 mode readback", 64'(d), 64'h107);
  endtask

  task automatic t_ignore_busy();
    int seen;
    logic [31:0] d;
    set_mode(1'b0, 7);
    bus_write(A_ADDR, {19'd0, 5'h09, 3'd0, 5'h02});
    bus_write(A_WDAT, 32'h0000_0F0F);
    rises = 0; rsp_en = 1'b0;
    bus_write(A_CMD, 32'h0000_0101);
    repeat (100) @(negedge clk);
    bus_write(A_CMD, 32'h0000_0100);
    wait_idle(seen);
    chk(line_v == exp_frame(1'b0, 2'd1, 5'h09, 5'h02, 16'h0F0F, 16'h0), "R8 frame unchanged",
        line_v, exp_frame(1'b0, 2'd1, 5'h09, 5'h02, 16'h0F0F, 16'h0));
    repeat (600) @(negedge clk);
    bus_read(A_CMD, d);
    chk(rises == 65 && d[16] == 1'b0, "R8 no second frame", 64'(rises), 64'd65);
  endtask

  task automatic t_bad_codes();
    logic [31:0] d;
    set_mode(1'b0, 7);
    rises = 0;
    bus_write(A_CMD, 32'h0000_0102);
    repeat (40) @(negedge clk);
    bus_read(A_CMD, d);
    chk(d[16] == 1'b0 && rises == 0 && mdc == 1'b0, "R9 clause22 code 2", 64'(rises), 64'd0);
    bus_write(A_CMD, 32'h0000_0103);
    repeat (40) @(negedge clk);
    chk(rises == 0 && mdc == 1'b0, "R9 clause22 code 3", 64'(rises), 64'd0);
    set_mode(1'b1, 7);
    bus_write(A_CMD, 32'h0000_0103);
    repeat (40) @(negedge clk);
    bus_read(A_CMD, d);
    chk(d[16] == 1'b0 && rises == 0 && mdc == 1'b0, "R9 clause45 code 3", 64'(rises), 64'd0);
  endtask

  initial begin
    #(150000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    set_mode(1'b0, 7);
    do_frame("R3 clause22 write frame", 1'b0, 2'd1, 5'h13, 5'h0A, 16'hA55A, 16'h0);
    do_frame("R4 clause22 read frame", 1'b0, 2'd0, 5'h05, 5'h1F, 16'h7777, 16'h3C96);
    set_mode(1'b1, 7);
    do_frame("R5 clause45 address frame", 1'b1, 2'd0, 5'h07, 5'h1E, 16'h1234, 16'h0);
    do_frame("R6 clause45 write frame", 1'b1, 2'd1, 5'h07, 5'h1E, 16'hBEEF, 16'h0);
    do_frame("R6 clause45 read frame", 1'b1, 2'd2, 5'h07, 5'h1E, 16'h0000, 16'h5A0F);
    set_mode(1'b0, 9);
    do_frame("R2 R3 write frame divider 10", 1'b0, 2'd1, 5'h1F, 5'h00, 16'h8001, 16'h0);
    t_ignore_busy();
    t_bad_codes();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule